// File: doc/BRIEF.md
# Dual-Port Command Mailbox with Hardware Semaphore

This block is a 512-byte shared mailbox between an internal bus and an external host. Each side has its own 9-bit address, 8-bit write data, write strobe, read strobe and registered read data, and both sides can reach the whole map in the same cycle. The map holds one command byte for each direction, a command-available flag for each direction, a two-bit ownership semaphore and a 507-byte data buffer.

A side posts a command by writing its command byte. This sets the matching available flag, which raises an interrupt toward the other side. The receiver reads the byte and then clears the flag. Before either side works on the data buffer, it can claim the semaphore by writing a claim value and reading the register back. A change of ownership that would break the protocol is refused in hardware. When both sides touch the semaphore or the same buffer byte in one cycle, the internal side takes priority.

Top module: `cmd_mailbox`

## Requirements
- R1: After a synchronous active-high reset, every register, the semaphore and all 507 buffer bytes read 00h, and both interrupts are low.
- R2: Map: 000h host-to-internal command, 001h internal-to-host command, 002h host-to-internal available flag (bit 0), 003h internal-to-host available flag (bit 0), 004h semaphore (bits 1:0, upper bits read 0), 005h to 1FFh data buffer. A read strobe in one cycle puts the addressed value on that side's read data after the next clock edge. The read data holds while the strobe is low.
- R3: A host write to 000h, or an internal write to 001h, stores the byte and sets the matching available flag. A write to a command register from the side that does not own it is ignored.
- R4: An available flag is cleared only when the receiving side writes 00h to it (internal clears 002h, host clears 003h). Any other write to a flag is ignored. If a new command is posted in the same cycle as the clear, the flag stays set.
- R5: host_irq is high exactly while the internal-to-host flag is set, and int_irq is high exactly while the host-to-internal flag is set.
- R6: Semaphore encoding: 00b free, 01b held by the internal side, 11b held by the host. An internal write of 01h or a host write of 03h takes the semaphore only when it is free. Otherwise the value is unchanged.
- R7: A write of 00h frees the semaphore only when the writer is the current owner. Otherwise the value is unchanged.
- R8: Any other byte written to 004h leaves the semaphore unchanged, and the value read back afterwards shows whether an operation took effect.
- R9: When both sides write 004h in the same cycle, the internal write is applied first and the host write is judged against the result.
- R10: Either side can read and write the data buffer without holding the semaphore, and each side sees bytes the other wrote.
- R11: When both sides write the same buffer byte in the same cycle, the internal side's value is kept.
- R12: A read of a location that is written in the same cycle returns the value it held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| int_addr | input | 9 | Internal side address |
| int_wdata | input | 8 | Internal side write data |
| int_wr | input | 1 | Internal side write strobe |
| int_rd | input | 1 | Internal side read strobe |
| int_rdata | output | 8 | Internal side read data, registered |
| host_addr | input | 9 | Host side address |
| host_wdata | input | 8 | Host side write data |
| host_wr | input | 1 | Host side write strobe |
| host_rd | input | 1 | Host side read strobe |
| host_rdata | output | 8 | Host side read data, registered |
| host_irq | output | 1 | Interrupt toward the host, high while a command waits for it |
| int_irq | output | 1 | Interrupt toward the internal side, high while a command waits for it |

## Verification
The assertions assume that each strobe is a clean level that is sampled once per clock, and that a write which is not aimed at 004h never changes the semaphore. Under these assumptions, ownership can pass from one side to the other only through the free state, except in a single cycle where the owner releases and the other side claims. The stimulus raises each strobe for exactly one clock and changes inputs only away from the rising edge. It sweeps every written byte value against each semaphore state and each side, and it combines claim, release and illegal values from both sides in the same cycle.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int MBX_AW       = 9;
    localparam int MBX_DW       = 8;
    localparam int MBX_BUF_BASE = 5;

    typedef enum logic [1:0] {
        SEM_FREE = 2'b00,
        SEM_INT  = 2'b01,
        SEM_BAD  = 2'b10,
        SEM_HOST = 2'b11
    } sem_e;

    typedef enum logic {
        SIDE_INT  = 1'b0,
        SIDE_HOST = 1'b1
    } side_e;

    typedef enum logic [2:0] {
        RG_CMD_H2I,
        RG_CMD_I2H,
        RG_AV_H2I,
        RG_AV_I2H,
        RG_SEM,
        RG_BUF
    } region_e;

    typedef struct packed {
        logic [MBX_DW-1:0] cmd_h2i;
        logic [MBX_DW-1:0] cmd_i2h;
        logic              av_h2i;
        logic              av_i2h;
    } cmd_state_t;

    function automatic region_e decode(input logic [MBX_AW-1:0] a);
        region_e r;
        case (a)
            MBX_AW'(0): r = RG_CMD_H2I;
            MBX_AW'(1): r = RG_CMD_I2H;
            MBX_AW'(2): r = RG_AV_H2I;
            MBX_AW'(3): r = RG_AV_I2H;
            MBX_AW'(4): r = RG_SEM;
            default:    r = RG_BUF;
        endcase
        return r;
    endfunction

    // One semaphore write from one side applied to a current value.
    function automatic sem_e sem_step(input sem_e cur, input logic [MBX_DW-1:0] w,
                                      input side_e side);
        sem_e              own;
        logic [MBX_DW-1:0] take;
        own  = (side == SIDE_HOST) ? SEM_HOST : SEM_INT;
        take = (side == SIDE_HOST) ? MBX_DW'(3) : MBX_DW'(1);
        if (w == take)
            return (cur == SEM_FREE) ? own : cur;
        else if (w == '0)
            return (cur == own) ? SEM_FREE : cur;
        else
            return cur;
    endfunction

endpackage

// File: rtl/mbx_sem.sv
module mbx_sem
    import mbx_pkg::*;
#(
    parameter int DW = MBX_DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          iw,
    input  logic [DW-1:0] iwdata,
    input  logic          hw,
    input  logic [DW-1:0] hwdata,
    output sem_e          sem_q
);

    sem_e after_int;
    sem_e after_host;

    // Internal side is applied first, host judged against the result.
    always_comb begin
        after_int  = iw ? sem_step(sem_q, MBX_DW'(iwdata), SIDE_INT) : sem_q;
        after_host = hw ? sem_step(after_int, MBX_DW'(hwdata), SIDE_HOST) : after_int;
    end

    always_ff @(posedge clk) begin
        if (rst) sem_q <= SEM_FREE;
        else     sem_q <= after_host;
    end

    // R6
    sem_legal_chk: assert property (@(posedge clk) disable iff (rst)
        sem_q != SEM_BAD);

    // R7
    int_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (sem_q == SEM_INT && !(iw && iwdata == '0)) |=> (sem_q == SEM_INT));

    // R7
    host_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (sem_q == SEM_HOST && !(hw && hwdata == '0)) |=> (sem_q != SEM_INT));

    // R8
    sem_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !(iw || hw) |=> $stable(sem_q));

endmodule

// File: rtl/mbx_cmd.sv
module mbx_cmd
    import mbx_pkg::*;
#(
    parameter int AW = MBX_AW,
    parameter int DW = MBX_DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          int_wr,
    input  logic [AW-1:0] int_addr,
    input  logic [DW-1:0] int_wdata,
    input  logic          host_wr,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    output cmd_state_t    st
);

    logic post_h2i, post_i2h, clr_h2i, clr_i2h;

    always_comb begin
        post_h2i = host_wr && decode(MBX_AW'(host_addr)) == RG_CMD_H2I;
        post_i2h = int_wr  && decode(MBX_AW'(int_addr))  == RG_CMD_I2H;
        clr_h2i  = int_wr  && decode(MBX_AW'(int_addr))  == RG_AV_H2I && int_wdata == '0;
        clr_i2h  = host_wr && decode(MBX_AW'(host_addr)) == RG_AV_I2H && host_wdata == '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            if (post_h2i) begin
                st.cmd_h2i <= MBX_DW'(host_wdata);
                st.av_h2i  <= 1'b1;
            end else if (clr_h2i) begin
                st.av_h2i  <= 1'b0;
            end
            if (post_i2h) begin
                st.cmd_i2h <= MBX_DW'(int_wdata);
                st.av_i2h  <= 1'b1;
            end else if (clr_i2h) begin
                st.av_i2h  <= 1'b0;
            end
        end
    end

    // R3
    post_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_addr == AW'(0)) |=> st.av_h2i);

    // R4
    flag_clear_src_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(st.av_h2i) |-> $past(int_wr && int_addr == AW'(2) && int_wdata == '0));

    // R4
    flag_clear_src2_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(st.av_i2h) |-> $past(host_wr && host_addr == AW'(3) && host_wdata == '0));

endmodule

// File: rtl/mbx_buf.sv
module mbx_buf
    import mbx_pkg::*;
#(
    parameter int AW   = MBX_AW,
    parameter int DW   = MBX_DW,
    parameter int BASE = MBX_BUF_BASE
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          iwe,
    input  logic [AW-1:0] iaddr,
    input  logic [DW-1:0] iwdata,
    input  logic          hwe,
    input  logic [AW-1:0] haddr,
    input  logic [DW-1:0] hwdata,
    output logic [DW-1:0] irdata,
    output logic [DW-1:0] hrdata
);

    localparam int DEPTH = (1 << AW) - BASE;
    localparam int IW    = $clog2(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic [IW-1:0] iidx, hidx;
    logic          iin, hin;

    always_comb begin
        iin    = iaddr >= AW'(BASE);
        hin    = haddr >= AW'(BASE);
        iidx   = iin ? IW'(iaddr - AW'(BASE)) : '0;
        hidx   = hin ? IW'(haddr - AW'(BASE)) : '0;
        irdata = mem[iidx];
        hrdata = mem[hidx];
    end

    // Host write first, internal write last so it wins on a collision.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
        end else begin
            if (hwe && hin) mem[hidx] <= hwdata;
            if (iwe && iin) mem[iidx] <= iwdata;
        end
    end

    // R11
    collide_chk: assert property (@(posedge clk) disable iff (rst)
        (iwe && hwe && iin && iaddr == haddr) |=> (irdata == $past(iwdata) || iaddr != $past(iaddr)));

endmodule

// File: rtl/cmd_mailbox.sv
module cmd_mailbox
    import mbx_pkg::*;
#(
    parameter int ADDR_W = MBX_AW,
    parameter int DATA_W = MBX_DW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] int_addr,
    input  logic [DATA_W-1:0] int_wdata,
    input  logic              int_wr,
    input  logic              int_rd,
    output logic [DATA_W-1:0] int_rdata,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              host_wr,
    input  logic              host_rd,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_irq,
    output logic              int_irq
);

    cmd_state_t        st;
    sem_e              sem;
    logic [DATA_W-1:0] buf_i, buf_h;
    logic              sem_iw, sem_hw;

    assign sem_iw = int_wr  && decode(MBX_AW'(int_addr))  == RG_SEM;
    assign sem_hw = host_wr && decode(MBX_AW'(host_addr)) == RG_SEM;

    mbx_sem #(.DW(DATA_W)) u_sem (
        .clk(clk), .rst(rst),
        .iw(sem_iw), .iwdata(int_wdata),
        .hw(sem_hw), .hwdata(host_wdata),
        .sem_q(sem)
    );

    mbx_cmd #(.AW(ADDR_W), .DW(DATA_W)) u_cmd (
        .clk(clk), .rst(rst),
        .int_wr(int_wr), .int_addr(int_addr), .int_wdata(int_wdata),
        .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
        .st(st)
    );

    mbx_buf #(.AW(ADDR_W), .DW(DATA_W), .BASE(MBX_BUF_BASE)) u_buf (
        .clk(clk), .rst(rst),
        .iwe(int_wr), .iaddr(int_addr), .iwdata(int_wdata),
        .hwe(host_wr), .haddr(host_addr), .hwdata(host_wdata),
        .irdata(buf_i), .hrdata(buf_h)
    );

    function automatic logic [DATA_W-1:0] view(input region_e r, input logic [DATA_W-1:0] b);
        case (r)
            RG_CMD_H2I: return DATA_W'(st.cmd_h2i);
            RG_CMD_I2H: return DATA_W'(st.cmd_i2h);
            RG_AV_H2I:  return DATA_W'(st.av_h2i);
            RG_AV_I2H:  return DATA_W'(st.av_i2h);
            RG_SEM:     return DATA_W'(sem);
            default:    return b;
        endcase
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            int_rdata  <= '0;
            host_rdata <= '0;
        end else begin
            if (int_rd)  int_rdata  <= view(decode(MBX_AW'(int_addr)), buf_i);
            if (host_rd) host_rdata <= view(decode(MBX_AW'(host_addr)), buf_h);
        end
    end

    assign host_irq = st.av_i2h;
    assign int_irq  = st.av_h2i;

    // R2
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !host_rd |=> $stable(host_rdata));

endmodule

// File: tb/cmd_mailbox_test.sv
module cmd_mailbox_test;

    logic       clk = 0;
    logic       rst = 1;
    logic [8:0] int_addr = '0, host_addr = '0;
    logic [7:0] int_wdata = '0, host_wdata = '0;
    logic       int_wr = 0, int_rd = 0, host_wr = 0, host_rd = 0;
    logic [7:0] int_rdata, host_rdata;
    logic       host_irq, int_irq;
    int         checks = 0;
    int         errors = 0;

    always #2 clk = ~clk;

    cmd_mailbox uut (
        .clk(clk), .rst(rst),
        .int_addr(int_addr), .int_wdata(int_wdata), .int_wr(int_wr), .int_rd(int_rd),
        .int_rdata(int_rdata),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_wr(host_wr), .host_rd(host_rd),
        .host_rdata(host_rdata),
        .host_irq(host_irq), .int_irq(int_irq)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
        int_wr = 0; int_rd = 0; host_wr = 0; host_rd = 0;
    endtask

    task automatic iwrite(input logic [8:0] a, input logic [7:0] d);
        int_addr = a; int_wdata = d; int_wr = 1; tick();
    endtask

    task automatic hwrite(input logic [8:0] a, input logic [7:0] d);
        host_addr = a; host_wdata = d; host_wr = 1; tick();
    endtask

    task automatic iread(input logic [8:0] a, output logic [7:0] d);
        int_addr = a; int_rd = 1; tick(); d = int_rdata;
    endtask

    task automatic hread(input logic [8:0] a, output logic [7:0] d);
        host_addr = a; host_rd = 1; tick(); d = host_rdata;
    endtask

    function automatic logic [1:0] sem_exp(input logic [1:0] cur, input logic [7:0] w, input bit host);
        if (!host && w == 8'h01 && cur == 2'b00) return 2'b01;
        if (host && w == 8'h03 && cur == 2'b00) return 2'b11;
        if (w == 8'h00 && ((host && cur == 2'b11) || (!host && cur == 2'b01))) return 2'b00;
        return cur;
    endfunction

    task automatic sem_to(input logic [1:0] s);
        iwrite(9'h004, 8'h00);
        hwrite(9'h004, 8'h00);
        if (s == 2'b01) iwrite(9'h004, 8'h01);
        if (s == 2'b11) hwrite(9'h004, 8'h03);
    endtask

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 37 + 11) & 255);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic [1:0] exps;
        repeat (3) @(posedge clk);
        #1 rst = 0;

        // R1 reset state
        chk("R1 host_irq", {7'b0, host_irq}, 8'h00);
        chk("R1 int_irq", {7'b0, int_irq}, 8'h00);
        for (int a = 0; a < 512; a++) begin
            iread(9'(a), d);
            chk("R1 reset read", d, 8'h00);
        end

        // R3 / R5 host posts a command
        hwrite(9'h000, 8'hA5);
        iread(9'h000, d); chk("R3 cmd_h2i", d, 8'hA5);
        iread(9'h002, d); chk("R3 av_h2i set", d, 8'h01);
        chk("R5 int_irq high", {7'b0, int_irq}, 8'h01);
        chk("R5 host_irq low", {7'b0, host_irq}, 8'h00);
        iwrite(9'h000, 8'h11);
        hread(9'h000, d); chk("R3 foreign cmd write ignored", d, 8'hA5);
        hwrite(9'h002, 8'h00);
        iread(9'h002, d); chk("R4 host clear of 002h ignored", d, 8'h01);
        iwrite(9'h002, 8'h07);
        iread(9'h002, d); chk("R4 nonzero write ignored", d, 8'h01);
        iwrite(9'h002, 8'h00);
        iread(9'h002, d); chk("R4 av_h2i cleared", d, 8'h00);
        chk("R5 int_irq low", {7'b0, int_irq}, 8'h00);

        // R3 / R5 internal posts a command
        iwrite(9'h001, 8'h3C);
        hread(9'h001, d); chk("R3 cmd_i2h", d, 8'h3C);
        hread(9'h003, d); chk("R3 av_i2h set", d, 8'h01);
        chk("R5 host_irq high", {7'b0, host_irq}, 8'h01);
        hwrite(9'h001, 8'h99);
        iread(9'h001, d); chk("R3 foreign cmd write ignored", d, 8'h3C);
        iwrite(9'h003, 8'h00);
        hread(9'h003, d); chk("R4 internal clear of 003h ignored", d, 8'h01);
        hwrite(9'h003, 8'h00);
        hread(9'h003, d); chk("R4 av_i2h cleared", d, 8'h00);
        chk("R5 host_irq low", {7'b0, host_irq}, 8'h00);

        // R4 post wins over a same-cycle clear
        hwrite(9'h000, 8'h42);
        host_addr = 9'h000; host_wdata = 8'h43; host_wr = 1;
        int_addr = 9'h002; int_wdata = 8'h00; int_wr = 1;
        tick();
        iread(9'h002, d); chk("R4 set wins", d, 8'h01);
        iread(9'h000, d); chk("R3 newest command", d, 8'h43);

        // R2 read data holds with no strobe
        hread(9'h000, d);
        tick();
        chk("R2 rdata hold", host_rdata, 8'h43);

        // R6 R7 R8 single-side sweep over every byte
        for (int s = 0; s < 4; s++) begin
            if (s == 2) continue;
            for (int side = 0; side < 2; side++) begin
                for (int w = 0; w < 256; w++) begin
                    sem_to(2'(s));
                    exps = sem_exp(2'(s), 8'(w), side == 1);
                    if (side == 1) begin
                        hwrite(9'h004, 8'(w));
                        hread(9'h004, d);
                    end else begin
                        iwrite(9'h004, 8'(w));
                        iread(9'h004, d);
                    end
                    chk("R6 R7 R8 semaphore", d, {6'b0, exps});
                end
            end
        end

        // R9 same-cycle semaphore writes
        for (int s = 0; s < 4; s++) begin
            if (s == 2) continue;
            for (int i = 0; i < 4; i++) begin
                for (int h = 0; h < 4; h++) begin
                    sem_to(2'(s));
                    exps = sem_exp(sem_exp(2'(s), 8'(i), 1'b0), 8'(h), 1'b1);
                    int_addr = 9'h004; int_wdata = 8'(i); int_wr = 1;
                    host_addr = 9'h004; host_wdata = 8'(h); host_wr = 1;
                    tick();
                    hread(9'h004, d);
                    chk("R9 ordered semaphore", d, {6'b0, exps});
                end
            end
        end

        // R10 buffer shared without semaphore, semaphore held by host
        sem_to(2'b11);
        for (int a = 5; a < 512; a++) begin
            if (a % 2 == 1) hwrite(9'(a), pat(a));
            else            iwrite(9'(a), pat(a));
        end
        for (int a = 5; a < 512; a++) begin
            if (a % 2 == 1) iread(9'(a), d);
            else            hread(9'(a), d);
            chk("R10 buffer cross read", d, pat(a));
        end

        // R11 same-byte collision
        int_addr = 9'h0F0; int_wdata = 8'h5A; int_wr = 1;
        host_addr = 9'h0F0; host_wdata = 8'hC3; host_wr = 1;
        tick();
        hread(9'h0F0, d); chk("R11 internal wins", d, 8'h5A);
        int_addr = 9'h1FF; int_wdata = 8'h01; int_wr = 1;
        host_addr = 9'h1FF; host_wdata = 8'hFE; host_wr = 1;
        tick();
        iread(9'h1FF, d); chk("R11 internal wins top byte", d, 8'h01);

        // R12 read during write returns the old value
        int_addr = 9'h100; int_wdata = 8'h77; int_wr = 1;
        host_addr = 9'h100; host_rd = 1;
        tick();
        chk("R12 old value", host_rdata, pat(256));
        hread(9'h100, d); chk("R12 new value after", d, 8'h77);
        hwrite(9'h000, 8'hE1);
        int_addr = 9'h000; int_rd = 1;
        host_addr = 9'h000; host_wdata = 8'hE2; host_wr = 1;
        tick();
        chk("R12 old command", int_rdata, 8'hE1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule